// File: doc/BRIEF.md
# Reset Cause Capture Register

This block keeps a small byte of sticky flags that tell software why the system last came out of reset. Four single-cycle event pulses drive it: power-on, external pin, watchdog timeout and brown-out. It also takes the watchdog's reset-enable control bit. Each flag has its own rules for being set and cleared, so the byte is more than a latch of the most recent cause. For example, a brown-out flag survives external and watchdog resets. A pure brown-out leaves the power-on flag clear, so software can tell a supply dip apart from a full power cycle.

The register sits in an always-on reset domain, which means ordinary system resets do not wipe it. Software reads the flags from the status output. It clears a flag by writing 1 to that flag's bit through a single-cycle synchronous write strobe. Every change becomes visible on the status output on the clock edge after the cause.

Top module: `rst_cause_rec`

## Requirements
- R1: After the always-on reset is released, the status byte reads 0x00.
- R2: A power-on pulse sets bit 0 (power-on) and bit 3 (brown-out) and clears bit 1 (external) and bit 2 (watchdog).
- R3: An external pulse sets bit 1 and clears bit 2. Bits 0 and 3 keep their values.
- R4: A watchdog pulse sets bit 2 only when the reset-enable input is 1. With the enable at 0, the pulse leaves the whole byte unchanged.
- R5: When a watchdog pulse arrives in the same cycle as any other event, the other event wins and bit 2 ends up 0.
- R6: A brown-out pulse sets bit 3 and leaves bits 0 and 1 unchanged. After a pure brown-out, software can therefore read bit 3 = 1 with bit 0 = 0.
- R7: A write clears every flag whose data bit is 1. Flags whose data bit is 0 keep their values.
- R8: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up 1.
- R9: Bits 7:4 always read 0, and writes to them change nothing.
- R10: When power-on and external pulses arrive together, bit 1 ends up 0 and bit 0 ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| aon_rst_n | input | 1 | Always-on domain reset, active low |
| ev_pwr_on | input | 1 | Power-on event pulse |
| ev_pin | input | 1 | External reset pin event pulse |
| ev_wdog | input | 1 | Watchdog timeout pulse |
| ev_brown | input | 1 | Brown-out event pulse |
| wdog_rst_en | input | 1 | Watchdog reset-enable control bit |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; a 1 in a bit clears that flag |
| cause | output | 8 | Sticky cause flags; bits 7:4 are always 0 |

## Verification
Two kinds of collision can land in the same cycle. A hardware event can meet a software write-one-to-clear on the same flag. Two hardware events can also compete for one flag: watchdog against another source, or power-on against external. The bench provokes each collision by pulsing both inputs in the same cycle from a flag state where either outcome is visible. It then judges the byte one edge later against the priority stated in R5, R8 and R10.

// File: rtl/rst_cause_rec.sv
module rst_cause_rec #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         aon_rst_n,
  input  logic         ev_pwr_on,
  input  logic         ev_pin,
  input  logic         ev_wdog,
  input  logic         ev_brown,
  input  logic         wdog_rst_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cause
);
  localparam int NF = 4;

  logic [NF-1:0] flg, clr, set_v, kill_v, flg_d;
  logic          wd_hit, other;

  assign clr    = wr_en ? wr_data[NF-1:0] : '0;
  assign wd_hit = ev_wdog & wdog_rst_en;
  assign other  = ev_pwr_on | ev_pin | ev_brown;

  assign set_v[0]  = ev_pwr_on;
  assign set_v[1]  = ev_pin & ~ev_pwr_on;
  assign set_v[2]  = wd_hit & ~other;
  assign set_v[3]  = ev_brown | ev_pwr_on;

  assign kill_v[0] = 1'b0;
  assign kill_v[1] = ev_pwr_on;
  assign kill_v[2] = other;
  assign kill_v[3] = 1'b0;

  assign flg_d = set_v | (flg & ~kill_v & ~clr);

  always_ff @(posedge clk or negedge aon_rst_n)
    if (!aon_rst_n) flg <= '0;
    else            flg <= flg_d;

  assign cause = {{(W-NF){1'b0}}, flg};
endmodule

module rst_cause_rec_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         aon_rst_n,
  input logic         ev_pwr_on,
  input logic         ev_pin,
  input logic         ev_wdog,
  input logic         ev_brown,
  input logic         wdog_rst_en,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] cause
);
  a_r2_por_effect: assert property (@(posedge clk) disable iff (!aon_rst_n)
    ev_pwr_on |=> (cause[0] && cause[3] && !cause[1] && !cause[2]));

  a_r3_pin_effect: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (ev_pin && !ev_pwr_on) |=> (cause[1] && !cause[2]));

  a_r4_wdog_gated: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (ev_wdog && !wdog_rst_en && !ev_pwr_on && !ev_pin && !ev_brown && !wr_en)
      |=> $stable(cause));

  a_r5_wdog_loses: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (ev_wdog && (ev_pwr_on || ev_pin || ev_brown)) |=> !cause[2]);

  a_r6_brown_kept: assert property (@(posedge clk) disable iff (!aon_rst_n)
    ((ev_pin || ev_wdog) && !ev_pwr_on && !ev_brown && !(wr_en && wr_data[3]))
      |=> $stable(cause[3]));

  a_r7_w1c_por: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (wr_en && wr_data[0] && !ev_pwr_on) |=> !cause[0]);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (ev_brown && wr_en && wr_data[3]) |=> cause[3]);

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (wr_en && (wr_data[W-1:4] != '0)) |=> (cause[W-1:4] == '0));
endmodule

bind rst_cause_rec rst_cause_rec_chk #(.W(W)) u_chk (.*);

// File: tb/rst_cause_rec_tb.sv
`timescale 1ns/1ps
module rst_cause_rec_tb;
  logic       clk = 0, aon_rst_n = 0;
  logic       ev_pwr_on = 0, ev_pin = 0, ev_wdog = 0, ev_brown = 0;
  logic       wdog_rst_en = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] cause;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  rst_cause_rec u_dut (.*);

  task automatic chk(string req, logic [7:0] exp);
    n_chk++;
    if (cause !== exp) begin
      n_bad++;
      $display("FAIL %s: cause=%02h expected=%02h", req, cause, exp);
    end
  endtask

  // drive one cycle of stimulus: {pwr, pin, wdog, brown}
  task automatic step(logic [3:0] ev, logic en, logic we, logic [7:0] d);
    {ev_pwr_on, ev_pin, ev_wdog, ev_brown} = ev;
    wdog_rst_en = en; wr_en = we; wr_data = d;
    @(negedge clk);
    {ev_pwr_on, ev_pin, ev_wdog, ev_brown} = '0;
    wr_en = 0; wr_data = 0;
  endtask

  task automatic t_reset; chk("R1", 8'h00); endtask

  task automatic t_por;
    step(4'b0110, 1, 0, 0);   // pin+wdog together: pin wins for wdog
    chk("R5", 8'h02);
    step(4'b0010, 1, 0, 0);
    chk("R4", 8'h06);
    step(4'b1000, 0, 0, 0);
    chk("R2", 8'h09);
  endtask

  task automatic t_pin;
    step(4'b0000, 0, 1, 8'h08); // clear brown only
    chk("R7", 8'h01);
    step(4'b0010, 1, 0, 0);
    chk("R4", 8'h05);
    step(4'b0100, 0, 0, 0);
    chk("R3", 8'h03);
  endtask

  task automatic t_wdog;
    step(4'b0000, 0, 1, 8'h0F);
    chk("R7", 8'h00);
    step(4'b0010, 0, 0, 0);
    chk("R4", 8'h00);
    step(4'b0010, 1, 0, 0);
    chk("R4", 8'h04);
    step(4'b0011, 1, 0, 0);  // wdog with brown: brown wins
    chk("R5", 8'h08);
  endtask

  task automatic t_brown;
    step(4'b0100, 0, 0, 0);
    chk("R3", 8'h0A);
    step(4'b0001, 0, 0, 0);
    chk("R6", 8'h0A);
    step(4'b0000, 0, 1, 8'h0F);
    step(4'b0001, 0, 0, 0);
    chk("R6", 8'h08);        // brown set, power-on clear
    step(4'b0100, 0, 0, 0);
    chk("R6", 8'h0A);
  endtask

  task automatic t_collide;
    step(4'b0001, 0, 1, 8'h0A);  // brown set vs clear; pin cleared
    chk("R8", 8'h08);
    step(4'b1000, 0, 1, 8'h01);
    chk("R8", 8'h09);
    step(4'b1110, 1, 0, 0);
    chk("R10", 8'h09);
    step(4'b0000, 0, 1, 8'h00);
    chk("R7", 8'h09);
  endtask

  task automatic t_reserved;
    step(4'b0000, 0, 1, 8'hF0);
    chk("R9", 8'h09);
    step(4'b0100, 0, 1, 8'hF1);
    chk("R9", 8'h0A);
  endtask

  initial begin : wdog_timer
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    aon_rst_n = 1;
    @(negedge clk);
    t_reset;
    t_por;
    t_pin;
    t_wdog;
    t_brown;
    t_collide;
    t_reserved;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule